// File: doc/BRIEF.md
# Function-Coded Integer Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for two operands of `WIDTH` bits (32 by default). A 3-bit function code picks the result. The most significant code bit is an invert control. When it is set, the second operand is complemented before it reaches every consumer, and a carry of one enters the shared adder. As a result, one adder serves for both the sum and the difference. The two low code bits steer a four-way output multiplexer. Its inputs are a bitwise AND, a bitwise OR, the adder result, and a one-bit compare result: the adder's top bit, zero-extended to full width.

The design drops straight into a datapath with no clock and no reset. The result and the zero indicator follow the inputs within one combinational settling time. Two parameters choose the internal variant. The adder can be a ripple chain or a parallel-prefix tree. The zero indicator can be kept or tied off.

Top module: `ctl_alu`

## Requirements
- R1: Code 000 yields the bitwise AND of the operands, and code 001 yields their bitwise OR.
- R2: Code 010 yields the operand sum modulo 2^32, and any carry out is dropped.
- R3: Code 110 yields the first operand minus the second, modulo 2^32. Equal operands give zero.
- R4: Code 100 yields first AND (NOT second), and code 101 yields first OR (NOT second).
- R5: Code 111 yields 0x00000001 when bit 31 of (first minus second) is 1, and 0x00000000 otherwise. For example, 25 and 32 give 0x00000001.
- R6: Code 011 yields bit 31 of (first plus second), zero-extended. Bits 31 to 1 of the result are always zero under codes 011 and 111.
- R7: The compare applies no overflow correction. First 0x80000000 with second 0x00000001 under code 111 gives 0. First 0x7FFFFFFF with second 0xFFFFFFFF gives 1.
- R8: The zero output is 1 exactly when all result bits are 0, under every code.
- R9: The result and the zero output depend only on the current operands and code, with no stored state. A change of input shows at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand, complemented when the code's top bit is 1 |
| func_i | input | 3 | Function code: bit 2 inverts, bits 1:0 select the output |
| res_o | output | 32 | Result |
| zero_o | output | 1 | High when the result is all zeros |

## Verification
The invert control acts on the logic unit and the adder in the same evaluation. The compare result is also drawn from that same adder, so a bad inversion or carry-in corrupts several outputs at once. The bench drives every one of the eight codes over the same cross product of corner operands (zero, all ones, 0x7FFFFFFF, 0x80000000, one) and over random pairs. Each result is judged against a reference computed arithmetically in the bench. The zero flag is judged in the same evaluation as the result it describes, so zero-producing cases such as equal operands under subtraction cover both functions at once.

// File: rtl/ctl_alu_pkg.sv
package ctl_alu_pkg;

   // output selector carried by the two low function bits
   typedef enum logic [1:0] {
      SEL_AND  = 2'b00,
      SEL_OR   = 2'b01,
      SEL_SUM  = 2'b10,
      SEL_SIGN = 2'b11
   } sel_e;

   // adder implementation variants
   localparam int ADDER_RIPPLE = 0;
   localparam int ADDER_PREFIX = 1;

   localparam int FUNC_W = 3;

endpackage

// File: rtl/ctl_alu_opcond.sv
module ctl_alu_opcond #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] opb_i,
   input  logic             inv_i,
   output logic [WIDTH-1:0] opb_eff_o
);

   always_comb begin
      opb_eff_o = inv_i ? ~opb_i : opb_i;
   end

   // inversion must flip every bit and nothing else
   always_comb begin
      if (inv_i) begin
         AST_INV_ALL_BITS: assert ((opb_eff_o ^ opb_i) == {WIDTH{1'b1}}); // R4
      end else begin
         AST_PASS_THROUGH: assert (opb_eff_o == opb_i); // R1
      end
   end

endmodule

// File: rtl/ctl_alu_adder.sv
module ctl_alu_adder #(
   parameter int WIDTH      = 32,
   parameter int ADDER_KIND = ctl_alu_pkg::ADDER_PREFIX
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o
);

   localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

   generate
      if (ADDER_KIND == ctl_alu_pkg::ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] carry;
         always_comb begin
            carry[0] = cin_i;
            for (int i = 0; i < WIDTH; i++) begin
               sum_o[i]     = x_i[i] ^ y_i[i] ^ carry[i];
               carry[i + 1] = (x_i[i] & y_i[i]) | (carry[i] & (x_i[i] ^ y_i[i]));
            end
         end
      end else if (ADDER_KIND == ctl_alu_pkg::ADDER_PREFIX) begin : g_prefix
         logic [LEVELS:0][WIDTH-1:0] gen;
         logic [LEVELS:0][WIDTH-1:0] prp;
         logic [WIDTH-1:0]           carry;
         always_comb begin
            gen[0] = x_i & y_i;
            prp[0] = x_i ^ y_i;
            for (int l = 1; l <= LEVELS; l++) begin
               for (int i = 0; i < WIDTH; i++) begin
                  if (i >= (1 << (l - 1))) begin
                     gen[l][i] = gen[l-1][i] | (prp[l-1][i] & gen[l-1][i - (1 << (l - 1))]);
                     prp[l][i] = prp[l-1][i] & prp[l-1][i - (1 << (l - 1))];
                  end else begin
                     gen[l][i] = gen[l-1][i];
                     prp[l][i] = prp[l-1][i];
                  end
               end
            end
            carry[0] = cin_i;
            for (int i = 1; i < WIDTH; i++) begin
               carry[i] = gen[LEVELS][i-1] | (prp[LEVELS][i-1] & cin_i);
            end
            sum_o = prp[0] ^ carry;
         end
      end else begin : g_bad_kind
         $error("ctl_alu_adder: unknown ADDER_KIND");
         assign sum_o = '0;
      end
   endgenerate

   // a number plus its complement with carry one is zero
   always_comb begin
      if (cin_i && (y_i == ~x_i)) begin
         AST_SUB_SELF_ZERO: assert (sum_o == '0); // R3
      end
      if (!cin_i && (y_i == '0)) begin
         AST_ADD_IDENTITY: assert (sum_o == x_i); // R2
      end
   end

endmodule

// File: rtl/ctl_alu_logic.sv
module ctl_alu_logic #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] or_o
);

   always_comb begin
      and_o = x_i & y_i;
      or_o  = x_i | y_i;
   end

   // every AND bit is also an OR bit
   always_comb begin
      AST_AND_WITHIN_OR: assert ((and_o & ~or_o) == '0); // R1
   end

endmodule

// File: rtl/ctl_alu_outmux.sv
module ctl_alu_outmux #(
   parameter int WIDTH   = 32,
   parameter bit ZERO_EN = 1'b1
) (
   input  ctl_alu_pkg::sel_e sel_i,
   input  logic [WIDTH-1:0]  and_i,
   input  logic [WIDTH-1:0]  or_i,
   input  logic [WIDTH-1:0]  sum_i,
   output logic [WIDTH-1:0]  res_o,
   output logic              zero_o
);

   always_comb begin
      unique case (sel_i)
         ctl_alu_pkg::SEL_AND:  res_o = and_i;
         ctl_alu_pkg::SEL_OR:   res_o = or_i;
         ctl_alu_pkg::SEL_SUM:  res_o = sum_i;
         ctl_alu_pkg::SEL_SIGN: res_o = {{(WIDTH-1){1'b0}}, sum_i[WIDTH-1]};
         default:               res_o = '0;
      endcase
   end

   generate
      if (ZERO_EN) begin : g_zero
         assign zero_o = ~|res_o;
      end else begin : g_no_zero
         assign zero_o = 1'b0;
      end
   endgenerate

   always_comb begin
      if (sel_i == ctl_alu_pkg::SEL_SIGN) begin
         AST_SIGN_NARROW: assert (res_o[WIDTH-1:1] == '0); // R6
         AST_SIGN_FOLLOWS: assert (res_o[0] == sum_i[WIDTH-1]); // R5
      end
      if (ZERO_EN && (sel_i == ctl_alu_pkg::SEL_SUM) && (sum_i != '0)) begin
         AST_ZERO_LOW: assert (!zero_o); // R8
      end
   end

endmodule

// File: rtl/ctl_alu.sv
module ctl_alu #(
   parameter int WIDTH      = 32,
   parameter int ADDER_KIND = ctl_alu_pkg::ADDER_PREFIX,
   parameter bit ZERO_EN    = 1'b1
) (
   input  logic [31:0] opa_i,
   input  logic [31:0] opb_i,
   input  logic [2:0]  func_i,
   output logic [31:0] res_o,
   output logic        zero_o
);

   localparam int TOP_BIT = WIDTH - 1;

   generate
      if (WIDTH != 32) begin : g_bad_width
         $error("ctl_alu: ports are fixed at 32 bits, WIDTH must be 32");
      end
      if ((ADDER_KIND != ctl_alu_pkg::ADDER_RIPPLE) &&
          (ADDER_KIND != ctl_alu_pkg::ADDER_PREFIX)) begin : g_bad_adder
         $error("ctl_alu: ADDER_KIND out of range");
      end
   endgenerate

   logic                 inv;
   ctl_alu_pkg::sel_e    sel;
   logic [WIDTH-1:0]     opb_eff;
   logic [WIDTH-1:0]     and_r;
   logic [WIDTH-1:0]     or_r;
   logic [WIDTH-1:0]     sum_r;

   assign inv = func_i[2];
   assign sel = ctl_alu_pkg::sel_e'(func_i[1:0]);

   ctl_alu_opcond #(.WIDTH(WIDTH)) opcond_i (
      .opb_i     (opb_i),
      .inv_i     (inv),
      .opb_eff_o (opb_eff)
   );

   ctl_alu_logic #(.WIDTH(WIDTH)) logic_i (
      .x_i   (opa_i),
      .y_i   (opb_eff),
      .and_o (and_r),
      .or_o  (or_r)
   );

   ctl_alu_adder #(.WIDTH(WIDTH), .ADDER_KIND(ADDER_KIND)) adder_i (
      .x_i   (opa_i),
      .y_i   (opb_eff),
      .cin_i (inv),
      .sum_o (sum_r)
   );

   ctl_alu_outmux #(.WIDTH(WIDTH), .ZERO_EN(ZERO_EN)) outmux_i (
      .sel_i  (sel),
      .and_i  (and_r),
      .or_i   (or_r),
      .sum_i  (sum_r),
      .res_o  (res_o),
      .zero_o (zero_o)
   );

   // top-level cross checks between ports
   always_comb begin
      if ((func_i == 3'b110) && (opa_i == opb_i)) begin
         AST_EQUAL_SUB_ZERO: assert (res_o == '0); // R3
      end
      if ((func_i == 3'b111) && (opa_i == opb_i)) begin
         AST_EQUAL_NOT_LESS: assert (res_o == '0); // R5
      end
      if ((func_i == 3'b101) && (opb_i == '0)) begin
         AST_ORN_ALL_ONES: assert (res_o == {WIDTH{1'b1}}); // R4
      end
      if (ZERO_EN && (res_o[TOP_BIT] || res_o[0])) begin
         AST_ZERO_CLEAR: assert (!zero_o); // R8
      end
   end

endmodule

// File: tb/ctl_alu_tb_top.sv
module ctl_alu_tb_top;

   logic        clk = 1'b0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic [2:0]  fn  = '0;
   logic [31:0] res;
   logic        zro;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk; // 50 MHz

   ctl_alu dut_i (
      .opa_i  (opa),
      .opb_i  (opb),
      .func_i (fn),
      .res_o  (res),
      .zero_o (zro)
   );

   function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                         input logic [2:0] c);
      logic [31:0] d;
      case (c)
         3'b000: return a & b;
         3'b001: return a | b;
         3'b010: return a + b;
         3'b011: begin d = a + b; return {31'd0, d[31]}; end
         3'b100: return a & ~b;
         3'b101: return a | ~b;
         3'b110: return a - b;
         default: begin d = a - b; return {31'd0, d[31]}; end
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] c);
      case (c)
         3'b000, 3'b001: return "R1";
         3'b010:         return "R2";
         3'b011:         return "R6";
         3'b100, 3'b101: return "R4";
         3'b110:         return "R3";
         default:        return "R5";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h (a=%h b=%h f=%b)", req, act, exp, opa, opb, fn);
      end
   endtask

   task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] c);
      logic [31:0] e;
      @(posedge clk);
      opa = a; opb = b; fn = c;
      #5;
      e = model(a, b, c);
      check(req_of(c), res, e);
      check("R8", {31'd0, zro}, {31'd0, (e == 32'd0)});
   endtask

   logic [31:0] corners [5] = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1};

   initial begin : watchdog
      #(20 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #5;
      // idle state: all-zero inputs give zero result and raised flag
      check("R1", res, 32'd0);
      check("R8", {31'd0, zro}, 32'd1);

      // R5 worked example
      apply(32'd25, 32'd32, 3'b111);
      check("R5", res, 32'h1);
      // R7 raw sign, no overflow correction
      apply(32'h8000_0000, 32'h1, 3'b111);
      check("R7", res, 32'h0);
      apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
      check("R7", res, 32'h1);
      // R3 equal operands subtract to zero, flag raised
      apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b110);
      check("R3", res, 32'h0);
      check("R8", {31'd0, zro}, 32'd1);
      // R2 carry dropped
      apply(32'hFFFF_FFFF, 32'h1, 3'b010);
      check("R2", res, 32'h0);

      // corner sweep over every code
      for (int c = 0; c < 8; c++)
         for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
               apply(corners[i], corners[j], 3'(c));

      // random sweep
      for (int c = 0; c < 8; c++)
         for (int k = 0; k < 300; k++)
            apply($urandom, $urandom, 3'(c));

      // R9 combinational: change inputs mid-cycle, no clock edge between
      @(negedge clk);
      opa = 32'd7; opb = 32'd9; fn = 3'b010;
      #1 check("R9", res, 32'd16);
      fn = 3'b110;
      #1 check("R9", res, 32'hFFFF_FFFE);
      opb = 32'd7;
      #1 check("R9", res, 32'd0);
      check("R9", {31'd0, zro}, 32'd1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule